// File: doc/BRIEF.md
# Programmable Reference Divider with Monitor Selector

This block divides a crystal reference clock by one of sixteen ratios picked by a 4-bit ratio code. The result is the comparison rate for a downstream phase comparator. The divider runs in the reference clock domain and presents the comparison rate in two forms:

- a one-cycle clock-enable pulse, once per comparison period;
- a registered square wave at the comparison frequency.

The ratio set mixes powers of two, ranging from 2 to 256, with a family built on five (5, 10, 20, 40, 80, 160, 320) and a single ratio of 24. Because of this, the counter has to handle odd and non-binary terminal counts.

A monitor output can show one of three things:

- the comparison pulse stream;
- a reference-rate qualifier that is high on every reference cycle;
- nothing, with the output held low.

Two control bits choose among these. They pass through a mode register, and that register starts with both bits set. For the first cycle after reset, the monitor therefore shows the comparison stream, whatever the control pins carry. A new ratio code is taken only when the counter reaches terminal count, so a code change never produces a shortened period.

Top module: `refdiv_top`

## Requirements
- R1: With ratio_code[3]=0, codes 0 to 7 select division ratios 2, 4, 8, 16, 32, 64, 128 and 256 respectively. The spacing of cmp_pulse equals the selected ratio in reference cycles.
- R2: With ratio_code[3]=1, codes 8 to 15 select ratios 24, 5, 10, 20, 40, 80, 160 and 320 respectively.
- R3: cmp_pulse is high for exactly one cycle per period. Its first pulse appears in the first cycle after rst is released.
- R4: Within each period, cmp_clk is high for ceil(N/2) cycles and low for floor(N/2) cycles, where N is the ratio. cmp_clk is low in the cycle that carries cmp_pulse.
- R5: A new ratio_code takes effect only at the next terminal count. The period in progress keeps its old length.
- R6: While rst is high, cmp_pulse, cmp_clk and mon_out are all 0.
- R7: The monitor mode register resets to enable=1, select=1. In the first cycle after reset, mon_out therefore equals cmp_pulse even when mon_en and mon_sel are both 0.
- R8: Two cycles after mon_en is sampled at 0, mon_out is held at 0.
- R9: Two cycles after mon_en=1 and mon_sel=1 are sampled, mon_out equals cmp_pulse in every cycle.
- R10: Two cycles after mon_en=1 and mon_sel=0 are sampled, mon_out is 1 in every cycle, acting as a qualifier at the reference rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_code | input | 4 | Division ratio code |
| mon_en | input | 1 | Monitor enable (0 holds mon_out low) |
| mon_sel | input | 1 | Monitor source: 1 comparison pulse, 0 reference qualifier |
| cmp_pulse | output | 1 | One-cycle pulse per comparison period |
| cmp_clk | output | 1 | Registered comparison-rate square wave |
| mon_out | output | 1 | Registered monitor output |

## Verification
The hardest case to reach is a code change in the middle of a period. It is only visible when the old ratio is long and the new one is short, so that a runt period would be obvious. The stimulus first loads ratio 320 and waits for the pulse that confirms the load. A few cycles into that period it switches to ratio 2. The bench then requires one period of exactly 320 cycles followed by periods of 2. The reset default of the mode register lasts only one cycle, so the bench holds both monitor pins at 0 through reset and samples mon_out in that single cycle.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  localparam int unsigned CODE_W    = 4;
  localparam int unsigned NUM_CODES = 2 ** CODE_W;
  localparam int unsigned BIN_BASE  = 2;
  localparam int unsigned ODD_BASE  = 5;
  localparam int unsigned ALT_ZERO  = 24;
  localparam int unsigned MAX_RATIO = 320;
  localparam int unsigned CNT_W     = $clog2(MAX_RATIO);

  // Division ratio for a code: the upper bit picks the family, the low bits the shift.
  function automatic int unsigned ratio_of(input int unsigned code);
    int unsigned sh;
    int unsigned fam;
    sh  = code & 32'd7;
    fam = (code >> 3) & 32'd1;
    if (fam == 0)
      return BIN_BASE << sh;
    else if (sh == 0)
      return ALT_ZERO;
    else
      return ODD_BASE << (sh - 1);
  endfunction

endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode
  import refdiv_pkg::*;
#(
  parameter int unsigned C_W = CODE_W,
  parameter int unsigned K_W = CNT_W
) (
  input  logic [C_W-1:0] code,
  output logic [K_W-1:0] load_val,
  output logic [K_W-1:0] half_val
);

  localparam int unsigned ENTRIES = 2 ** C_W;

  logic [K_W-1:0] load_tbl [ENTRIES];
  logic [K_W-1:0] half_tbl [ENTRIES];

  // One table slot per code, filled from the ratio function.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_tbl
    assign load_tbl[i] = K_W'(ratio_of(i) - 1);
    assign half_tbl[i] = K_W'(ratio_of(i) / 2);
  end

  assign load_val = load_tbl[code];
  assign half_val = half_tbl[code];

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int unsigned K_W = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [K_W-1:0] load_val,
  input  logic [K_W-1:0] half_val,
  output logic           term,
  output logic           pulse_q,
  output logic           square_q
);

  logic [K_W-1:0] cnt;
  logic [K_W-1:0] act_half;

  assign term = (cnt == '0);

  // The active ratio is captured only at terminal count, so a period is never cut short.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      act_half <= '0;
      pulse_q  <= 1'b0;
      square_q <= 1'b0;
    end else begin
      if (term) begin
        cnt      <= load_val;
        act_half <= half_val;
      end else begin
        cnt <= cnt - 1'b1;
      end
      pulse_q  <= term;
      square_q <= !term && (cnt >= act_half);
    end
  end

endmodule

// File: rtl/refdiv_monsel.sv
module refdiv_monsel (
  input  logic clk,
  input  logic rst,
  input  logic en_in,
  input  logic sel_in,
  input  logic term,
  output logic mon_q
);

  logic en_q;
  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b1;
      sel_q <= 1'b1;
      mon_q <= 1'b0;
    end else begin
      en_q  <= en_in;
      sel_q <= sel_in;
      if (!en_q)
        mon_q <= 1'b0;
      else if (sel_q)
        mon_q <= term;
      else
        mon_q <= 1'b1;
    end
  end

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int unsigned C_W = CODE_W,
  parameter int unsigned K_W = CNT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [C_W-1:0] ratio_code,
  input  logic           mon_en,
  input  logic           mon_sel,
  output logic           cmp_pulse,
  output logic           cmp_clk,
  output logic           mon_out
);

  logic [K_W-1:0] load_val;
  logic [K_W-1:0] half_val;
  logic           term;

  refdiv_decode #(.C_W(C_W), .K_W(K_W)) u_decode (
    .code     (ratio_code),
    .load_val (load_val),
    .half_val (half_val)
  );

  refdiv_counter #(.K_W(K_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .load_val (load_val),
    .half_val (half_val),
    .term     (term),
    .pulse_q  (cmp_pulse),
    .square_q (cmp_clk)
  );

  refdiv_monsel u_monsel (
    .clk    (clk),
    .rst    (rst),
    .en_in  (mon_en),
    .sel_in (mon_sel),
    .term   (term),
    .mon_q  (mon_out)
  );

endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
  parameter int unsigned MAX_GAP = 320
) (
  input logic clk,
  input logic rst,
  input logic mon_en,
  input logic mon_sel,
  input logic cmp_pulse,
  input logic cmp_clk,
  input logic mon_out
);

  logic [1:0]  since;
  logic        seen;
  logic [15:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      seen  <= 1'b0;
      gap   <= '0;
    end else begin
      if (since != 2'd3) since <= since + 1'b1;
      if (cmp_pulse) begin
        seen <= 1'b1;
        gap  <= 16'd1;
      end else if (gap != 16'hFFFF) begin
        gap <= gap + 1'b1;
      end
    end
  end

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    cmp_pulse |=> !cmp_pulse);

  p_gap_range_r1: assert property (@(posedge clk) disable iff (rst)
    (seen && cmp_pulse) |-> (gap >= 16'd2 && gap <= 16'(MAX_GAP)));

  p_sq_low_at_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    cmp_pulse |-> !cmp_clk);

  p_mon_off_r8: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2 && !$past(mon_en, 2)) |-> !mon_out);

  p_mon_cmp_r9: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2 && $past(mon_en, 2) && $past(mon_sel, 2)) |-> (mon_out == cmp_pulse));

  p_mon_ref_r10: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2 && $past(mon_en, 2) && !$past(mon_sel, 2)) |-> mon_out);

endmodule

bind refdiv_top refdiv_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .mon_en    (mon_en),
  .mon_sel   (mon_sel),
  .cmp_pulse (cmp_pulse),
  .cmp_clk   (cmp_clk),
  .mon_out   (mon_out)
);

// File: tb/refdiv_top_bench.sv
module refdiv_top_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ratio_code = 4'd0;
  logic       mon_en = 1'b0;
  logic       mon_sel = 1'b0;
  logic       cmp_pulse;
  logic       cmp_clk;
  logic       mon_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  refdiv_top u_refdiv_top (
    .clk        (clk),
    .rst        (rst),
    .ratio_code (ratio_code),
    .mon_en     (mon_en),
    .mon_sel    (mon_sel),
    .cmp_pulse  (cmp_pulse),
    .cmp_clk    (cmp_clk),
    .mon_out    (mon_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ratio(input int code);
    if (code < 8) return 2 << code;
    if (code == 8) return 24;
    return 5 << (code - 9);
  endfunction

  task automatic wait_pulse();
    do @(negedge clk); while (!cmp_pulse);
  endtask

  task automatic measure(output int period, output int high);
    period = 0;
    high = 0;
    do begin
      @(negedge clk);
      period++;
      if (cmp_clk) high++;
    end while (!cmp_pulse);
  endtask

  // R6, R3, R7, R8: reset values, first pulse, one-cycle mode default
  task automatic t_reset();
    mon_en = 1'b0;
    mon_sel = 1'b0;
    ratio_code = 4'd9;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(!cmp_pulse && !cmp_clk && !mon_out, "R6 outputs in reset",
          {cmp_pulse, cmp_clk, mon_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(cmp_pulse, "R3 first pulse after reset", cmp_pulse, 1);
    check(mon_out, "R7 default mode mirrors pulse", mon_out, 1);
    @(negedge clk);
    check(!mon_out, "R8 mon low once pins sampled", mon_out, 0);
    check(!cmp_pulse, "R3 pulse lasts one cycle", cmp_pulse, 0);
  endtask

  // R1, R2, R4: every code, two periods each
  task automatic t_all_codes();
    int p;
    int h;
    for (int c = 0; c < 16; c++) begin
      ratio_code = 4'(c);
      wait_pulse();
      for (int k = 0; k < 2; k++) begin
        measure(p, h);
        if (c < 8) check(p == exp_ratio(c), "R1 period", p, exp_ratio(c));
        else       check(p == exp_ratio(c), "R2 period", p, exp_ratio(c));
        check(h == (exp_ratio(c) + 1) / 2, "R4 high cycles", h, (exp_ratio(c) + 1) / 2);
      end
    end
  endtask

  // R5: switch from 320 to 2 part way through a period
  task automatic t_switch();
    int p;
    int h;
    ratio_code = 4'd15;
    wait_pulse();
    repeat (3) @(negedge clk);
    ratio_code = 4'd0;
    measure(p, h);
    check(p == 317, "R5 remainder of old period", p, 317);
    measure(p, h);
    check(p == 2, "R5 new ratio after terminal", p, 2);
    measure(p, h);
    check(p == 2, "R5 new ratio holds", p, 2);
  endtask

  // R8, R9, R10: monitor modes, ratio 5
  task automatic t_monitor();
    int bad;
    ratio_code = 4'd9;
    mon_en = 1'b1;
    mon_sel = 1'b1;
    repeat (3) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mon_out != cmp_pulse) bad++;
    end
    check(bad == 0, "R9 mon follows pulse", bad, 0);
    mon_sel = 1'b0;
    repeat (3) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!mon_out) bad++;
    end
    check(bad == 0, "R10 mon high each cycle", bad, 0);
    mon_en = 1'b0;
    repeat (3) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mon_out) bad++;
    end
    check(bad == 0, "R8 mon held low", bad, 0);
  endtask

  initial begin
    t_reset();
    t_all_codes();
    t_switch();
    t_monitor();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule